// File: doc/BRIEF.md
# Receive Descriptor List Engine

This block is the receive-side control machine of a network interface. Host software builds a chain of receive descriptors in memory. Each descriptor is three words: a link to the next descriptor, a command/status word, and the address of a data buffer. Words arriving from the wire are queued in a small frame FIFO. The engine fetches the descriptor at its current pointer and copies one frame, word by word, into that descriptor's buffer. It then writes a status word back and follows the link to the next descriptor.

Software steers the engine through a command register write carrying enable, disable and receiver-reset bits. It can also write the descriptor pointer directly. The engine keeps its own enable flag apart from the stored command bits, and a disable bit always beats an enable bit. A disabled engine finishes the frame in progress and stops only at a descriptor boundary. Incoming words are refused only while the flag is clear, never merely because the machine is idle. Two single-cycle interrupt requests report a finished descriptor and a return to idle. Memory is reached through a one-word request/grant port.

Top module: `rxd_engine`

## Requirements
- R1: On a command write, bit 1 (disable) set clears the enable flag, even when bit 0 (enable) is set in the same write.
- R2: A command write with bit 0 set and bits 1 and 2 clear sets the enable flag. If the machine is idle, it starts on the next cycle by reading the word at the current descriptor pointer.
- R3: While idle with the enable flag clear, the machine stays idle and issues no memory request.
- R4: Descriptor words are link at offset +0, status at +1 and buffer address at +2. If the status word read has bit 31 (host-owned) set, the machine pulses the idle interrupt, returns to idle and writes nothing.
- R5: Frame words are written to consecutive addresses starting at the buffer address. The status word written back to offset +1 has bit 31 set, bit 29 copied from the fetched status, and bits 15:0 holding the frame length in words.
- R6: After writeback, a fetched status with bit 29 (interrupt request) set gives exactly one descriptor-interrupt pulse. With that bit clear there is none.
- R7: If the enable flag is clear when writeback completes, the machine goes idle. It leaves the descriptor pointer unchanged and posts no interrupt.
- R8: After writeback with the flag set, a zero link pulses the idle interrupt, sets the done flag and goes idle. A nonzero link is loaded into the descriptor pointer and that descriptor is read.
- R9: A descriptor pointer write loads the pointer and clears the done flag.
- R10: Wire words are dropped while the enable flag is clear. While the flag is set they are queued, even when the machine is idle, and are delivered once a descriptor is fetched.
- R11: A command write with bit 2 (receiver reset) set clears the enable flag, the done flag, the FIFO and the length count, and forces idle. The command register output still shows the written value.
- R12: Each interrupt request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | CMD_W | Command value: bit 0 enable, bit 1 disable, bit 2 receiver reset |
| dp_wr | input | 1 | Descriptor pointer write strobe |
| dp_wdata | input | AW | New descriptor pointer |
| rx_valid | input | 1 | Wire word valid |
| rx_data | input | DW | Wire word |
| rx_last | input | 1 | Marks the final word of a frame |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| irq_desc | output | 1 | Descriptor interrupt pulse |
| irq_idle | output | 1 | Idle interrupt pulse |
| stat_enable | output | 1 | Internal enable flag |
| stat_done | output | 1 | Current-descriptor-done flag |
| stat_idle | output | 1 | Machine is in its idle state |
| stat_dp | output | AW | Current descriptor pointer |
| cmd_reg | output | CMD_W | Last command value written |

## Verification
A wrong enable flag shows up at the ports on the cycle after the command write, through stat_enable. Within one or two memory grants it also shows as a missing or unexpected request on the memory port. A FIFO that accepted words while disabled, or that survived a receiver reset, shows up later as buffer writes that should not happen. The bench holds the engine waiting on an empty queue for tens of cycles and counts memory writes to catch this. Errors in the status word, link following or halting show up in memory contents, in stat_dp and in the interrupt counts as soon as a descriptor completes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_DIS_BIT = 1;
    localparam int CMD_RST_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_RD,
        ST_XFER,
        ST_WBACK,
        ST_ADVANCE
    } rxd_state_e;
endpackage

// File: rtl/rxd_cmd_dec.sv
module rxd_cmd_dec
    import rxd_pkg::*;
#(
    parameter int CMD_W = 3
) (
    input  logic             wr,
    input  logic [CMD_W-1:0] wdata,
    output logic             do_reset,
    output logic             do_disable,
    output logic             do_enable
);
    // Priority: reset, then disable, then enable.
    always_comb begin
        do_reset   = wr && wdata[CMD_RST_BIT];
        do_disable = wr && !wdata[CMD_RST_BIT] && wdata[CMD_DIS_BIT];
        do_enable  = wr && !wdata[CMD_RST_BIT] && !wdata[CMD_DIS_BIT] && wdata[CMD_EN_BIT];
    end

    always_comb begin
        assert (!(do_reset && do_enable) && !(do_disable && do_enable))
            else $error("p_dec_excl_r1: enable decoded together with disable or reset");
    end
endmodule

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW:0]   cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] store_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (PW+1)'(DEPTH));
    assign count = q.cnt;
    assign rdata = store_q[q.rd];
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push_ok) d.wr = (q.wr == PW'(DEPTH-1)) ? '0 : q.wr + 1'b1;
            if (pop_ok)  d.rd = (q.rd == PW'(DEPTH-1)) ? '0 : q.rd + 1'b1;
            d.cnt = q.cnt + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) store_q[q.wr] <= wdata;
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (PW+1)'(DEPTH));
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CMD_W      = 3,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             dp_wr,
    input  logic [AW-1:0]    dp_wdata,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_last,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    output logic             irq_desc,
    output logic             irq_idle,
    output logic             stat_enable,
    output logic             stat_done,
    output logic             stat_idle,
    output logic [AW-1:0]    stat_dp,
    output logic [CMD_W-1:0] cmd_reg
);
    localparam int OWN_B      = DW - 1;
    localparam int INTR_B     = DW - 3;
    localparam int DESC_WORDS = 3;
    localparam int FW         = DW + 1;
    localparam int CW         = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        rxd_state_e       state;
        logic             en;
        logic             done;
        logic [AW-1:0]    dp;
        logic [1:0]       idx;
        logic [AW-1:0]    link;
        logic             intr;
        logic [AW-1:0]    frag;
        logic [LEN_W-1:0] len;
        logic             irq_desc;
        logic             irq_idle;
        logic [CMD_W-1:0] cmd;
    } regs_t;

    regs_t q, d;

    logic do_reset, do_disable, do_enable;
    logic fifo_push, fifo_pop, fifo_clr, fifo_empty, fifo_full;
    logic [FW-1:0] fifo_rdata;
    logic [CW-1:0] fifo_count;
    logic [DW-1:0] wb_word;

    rxd_cmd_dec #(.CMD_W(CMD_W)) u_dec (
        .wr(cmd_wr), .wdata(cmd_wdata),
        .do_reset(do_reset), .do_disable(do_disable), .do_enable(do_enable)
    );

    assign fifo_push = rx_valid && q.en;

    rxd_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(fifo_push), .wdata({rx_last, rx_data}),
        .pop(fifo_pop), .rdata(fifo_rdata),
        .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
    );

    always_comb begin
        wb_word = '0;
        wb_word[OWN_B] = 1'b1;
        wb_word[INTR_B] = q.intr;
        wb_word[LEN_W-1:0] = q.len;
    end

    always_comb begin
        d = q;
        d.irq_desc = 1'b0;
        d.irq_idle = 1'b0;
        mem_req = 1'b0;
        mem_we = 1'b0;
        mem_addr = q.dp;
        mem_wdata = wb_word;
        fifo_pop = 1'b0;
        fifo_clr = 1'b0;

        unique case (q.state)
            ST_IDLE: ;
            ST_DESC_RD: begin
                mem_req = 1'b1;
                mem_addr = q.dp + AW'(q.idx);
                if (mem_gnt) begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == 2'd0) d.link = mem_rdata[AW-1:0];
                    if (q.idx == 2'd1) d.intr = mem_rdata[INTR_B];
                    if (q.idx == 2'd1 && mem_rdata[OWN_B]) begin
                        d.irq_idle = 1'b1;
                        d.state = ST_IDLE;
                    end
                    if (q.idx == 2'(DESC_WORDS-1)) begin
                        d.frag = mem_rdata[AW-1:0];
                        d.len = '0;
                        d.state = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                mem_req = !fifo_empty;
                mem_we = 1'b1;
                mem_addr = q.frag;
                mem_wdata = fifo_rdata[DW-1:0];
                if (mem_gnt && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.frag = q.frag + 1'b1;
                    d.len = q.len + 1'b1;
                    if (fifo_rdata[DW]) d.state = ST_WBACK;
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we = 1'b1;
                mem_addr = q.dp + AW'(1);
                if (mem_gnt) begin
                    d.irq_desc = q.intr;
                    d.state = q.en ? ST_ADVANCE : ST_IDLE;
                end
            end
            ST_ADVANCE: begin
                if (q.link == '0) begin
                    d.irq_idle = 1'b1;
                    d.done = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.dp = q.link;
                    d.idx = '0;
                    d.state = ST_DESC_RD;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (cmd_wr) d.cmd = cmd_wdata;
        if (do_reset) begin
            d.en = 1'b0;
            d.done = 1'b0;
            d.len = '0;
            d.state = ST_IDLE;
            fifo_clr = 1'b1;
        end else if (do_disable) begin
            d.en = 1'b0;
        end else if (do_enable) begin
            d.en = 1'b1;
            if (q.state == ST_IDLE) begin
                d.state = ST_DESC_RD;
                d.idx = '0;
            end
        end

        if (dp_wr) begin
            d.dp = dp_wdata;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign irq_desc = q.irq_desc;
    assign irq_idle = q.irq_idle;
    assign stat_enable = q.en;
    assign stat_done = q.done;
    assign stat_idle = (q.state == ST_IDLE);
    assign stat_dp = q.dp;
    assign cmd_reg = q.cmd;

    p_dis_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_wdata[CMD_DIS_BIT] |=> !stat_enable);
    p_kick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_wdata[CMD_EN_BIT] && !cmd_wdata[CMD_DIS_BIT] && !cmd_wdata[CMD_RST_BIT]
        && stat_idle |=> stat_enable && mem_req && !mem_we);
    p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_idle && !stat_enable && !cmd_wr |=> stat_idle && !mem_req);
    p_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_gnt && mem_rdata[OWN_B] && q.idx == 2'd1 && !cmd_wr
        |=> irq_idle && stat_idle);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt && !cmd_wr && !dp_wr |=> mem_req && $stable(mem_addr));
    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_WBACK && mem_gnt && !stat_enable && !cmd_wr && !dp_wr
        |=> stat_idle && $stable(stat_dp));
    p_dp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dp_wr |=> !stat_done && stat_dp == $past(dp_wdata));
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !stat_enable && !fifo_pop && !cmd_wr |=> $stable(fifo_count));
    p_rx_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_wdata[CMD_RST_BIT]
        |=> stat_idle && !stat_enable && fifo_empty && cmd_reg == $past(cmd_wdata));
    p_pulse_desc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_desc |=> !irq_desc);
    p_pulse_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idle |=> !irq_idle);
endmodule

// File: tb/tb_rxd_engine.sv
module tb_rxd_engine;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 3;
    localparam logic [2:0] C_EN = 3'b001, C_DIS = 3'b010, C_RST = 3'b100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [CW-1:0] cmd_wdata = '0;
    logic dp_wr = 1'b0;
    logic [AW-1:0] dp_wdata = '0;
    logic rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic rx_last = 1'b0;
    logic mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic irq_desc, irq_idle, stat_enable, stat_done, stat_idle;
    logic [AW-1:0] stat_dp;
    logic [CW-1:0] cmd_reg;

    always #10 clk = ~clk;

    rxd_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .irq_desc(irq_desc), .irq_idle(irq_idle), .stat_enable(stat_enable),
        .stat_done(stat_done), .stat_idle(stat_idle), .stat_dp(stat_dp), .cmd_reg(cmd_reg)
    );

    // Memory model: grant one negedge after a request is seen.
    logic [31:0] mem [256];
    int wcount = 0;
    int n_desc = 0, n_idle = 0, n_long = 0;
    logic prev_desc = 1'b0, prev_idle = 1'b0;
    int errors = 0, checks = 0, cycles = 0;
    bit done_flag = 0;

    initial begin
        mem_gnt = 1'b0;
        mem_rdata = '0;
    end

    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt <= 1'b0;
        end else if (mem_req && rst_n) begin
            mem_gnt <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wcount <= wcount + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
            end
        end
        if (irq_desc) n_desc <= n_desc + 1;
        if (irq_idle) n_idle <= n_idle + 1;
        if ((irq_desc && prev_desc) || (irq_idle && prev_idle)) n_long <= n_long + 1;
        prev_desc <= irq_desc;
        prev_idle <= irq_idle;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            finish_up();
        end
    end

    task automatic cmd_write(input logic [2:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic dp_write(input logic [31:0] v);
        @(negedge clk); dp_wr = 1'b1; dp_wdata = v;
        @(negedge clk); dp_wr = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + i; rx_last = (i == n - 1);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && !stat_idle; i++) @(negedge clk);
    endtask

    task automatic set_desc(input logic [7:0] a, input logic [31:0] link,
                            input logic [31:0] cs, input logic [31:0] buf_a);
        mem[a] = link; mem[a + 1] = cs; mem[a + 2] = buf_a;
    endtask

    int wsave;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        set_desc(8'h10, 32'h20, 32'h2000_0000, 32'h80);
        set_desc(8'h20, 32'h0, 32'h0, 32'h90);
        set_desc(8'h30, 32'h40, 32'h8000_0000, 32'hA0);
        set_desc(8'h40, 32'h50, 32'h0, 32'hB0);
        set_desc(8'h60, 32'h0, 32'h0, 32'hC0);
        set_desc(8'h70, 32'h0, 32'h0, 32'hD0);
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);

        // reset state
        check("R3 reset idle", 32'(stat_idle), 1);
        check("R3 reset enable", 32'(stat_enable), 0);
        check("R8 reset done", 32'(stat_done), 0);

        // R1: disable wins over enable
        cmd_write(C_EN | C_DIS);
        check("R1 enable after en+dis", 32'(stat_enable), 0);
        check("R1 cmd_reg holds value", 32'(cmd_reg), 32'(C_EN | C_DIS));
        // R3: disabled idle stays quiet
        wait_cycles(10);
        check("R3 still idle", 32'(stat_idle), 1);
        check("R3 no memory request", 32'(mem_req), 0);

        // R10: words dropped while disabled
        dp_write(32'h10);
        check("R9 dp loaded", stat_dp, 32'h10);
        send_frame(3, 32'hDEAD_0000);

        // R2: enable kicks from idle at current pointer
        cmd_write(C_EN);
        check("R2 enable flag", 32'(stat_enable), 1);
        check("R2 first request", {31'(mem_req), mem_we}, 32'h2);
        check("R2 first address", mem_addr, 32'h10);
        wait_cycles(30);
        check("R10 dropped frame not written", wcount, 0);
        check("R10 engine waiting", 32'(stat_idle), 0);

        // R5/R6: frame into descriptor A with interrupt request
        send_frame(3, 32'hA5A5_0000);
        wait_cycles(40);
        for (int i = 0; i < 3; i++)
            check("R5 buffer A word", mem[8'h80 + i], 32'hA5A5_0000 + i);
        check("R5 status A", mem[8'h11], 32'hA000_0003);
        check("R6 one desc irq", n_desc, 1);
        check("R8 link followed", stat_dp, 32'h20);

        // R8: zero link ends the list
        send_frame(2, 32'hB0B0_0000);
        wait_idle();
        wait_cycles(2);
        check("R5 buffer B word0", mem[8'h90], 32'hB0B0_0000);
        check("R5 buffer B word1", mem[8'h91], 32'hB0B0_0001);
        check("R5 status B", mem[8'h21], 32'h8000_0002);
        check("R6 no irq without request bit", n_desc, 1);
        check("R8 idle irq on zero link", n_idle, 1);
        check("R8 done set", 32'(stat_done), 1);
        check("R8 dp stays at last", stat_dp, 32'h20);
        check("R12 pulses single cycle", n_long, 0);

        // R9: pointer write clears done
        dp_write(32'h30);
        check("R9 done cleared", 32'(stat_done), 0);
        check("R9 dp loaded", stat_dp, 32'h30);

        // R4: host-owned descriptor
        wsave = wcount;
        cmd_write(C_EN);
        wait_cycles(12);
        check("R4 idle after owned", 32'(stat_idle), 1);
        check("R4 idle irq", n_idle, 2);
        check("R4 no writes", wcount, wsave);
        check("R4 enable kept", 32'(stat_enable), 1);

        // R10: accepted while idle but enabled
        send_frame(2, 32'hC1C1_0000);
        mem[8'h31] = 32'h0;
        cmd_write(C_EN);
        for (int i = 0; i < 500 && stat_dp != 32'h40; i++) @(negedge clk);
        wait_cycles(10);
        check("R10 queued word0 delivered", mem[8'hA0], 32'hC1C1_0000);
        check("R10 queued word1 delivered", mem[8'hA1], 32'hC1C1_0001);
        check("R5 status len 2", mem[8'h31], 32'h8000_0002);

        // R7: disable mid-frame halts at the boundary
        send_frame(4, 32'hD4D4_0000);
        cmd_write(C_DIS);
        check("R7 flag cleared", 32'(stat_enable), 0);
        wait_idle();
        wait_cycles(2);
        for (int i = 0; i < 4; i++)
            check("R7 frame finished", mem[8'hB0 + i], 32'hD4D4_0000 + i);
        check("R7 status written", mem[8'h41], 32'h8000_0004);
        check("R7 dp not advanced", stat_dp, 32'h40);
        check("R7 idle", 32'(stat_idle), 1);
        check("R7 no irq on halt", n_idle, 2);

        // R11: receiver reset
        dp_write(32'h60);
        cmd_write(C_EN);
        send_frame(1, 32'h0000_600D);
        wait_idle();
        wait_cycles(2);
        check("R5 single word", mem[8'hC0], 32'h0000_600D);
        check("R8 done before reset", 32'(stat_done), 1);
        check("R8 idle irq count", n_idle, 3);
        send_frame(2, 32'hEEEE_0000);
        cmd_write(C_RST | C_EN);
        check("R11 enable cleared", 32'(stat_enable), 0);
        check("R11 done cleared", 32'(stat_done), 0);
        check("R11 idle", 32'(stat_idle), 1);
        check("R11 cmd_reg kept", 32'(cmd_reg), 32'(C_RST | C_EN));
        dp_write(32'h70);
        wsave = wcount;
        cmd_write(C_EN);
        wait_cycles(30);
        check("R11 fifo emptied", wcount, wsave);
        send_frame(1, 32'h0000_7777);
        wait_idle();
        wait_cycles(2);
        check("R11 new frame delivered", mem[8'hD0], 32'h0000_7777);
        check("R11 status", mem[8'h71], 32'h8000_0001);
        check("R12 pulses single cycle", n_long, 0);
        check("R6 total desc irqs", n_desc, 1);

        finish_up();
    end
endmodule